// File: doc/BRIEF.md
# Stream ID to context mapper

This block turns the 16-bit identifier carried by an incoming transaction into a routing decision. The decision is one of three: translate through a numbered context bank, pass through untranslated (bypass), or fault. The decision comes from a table of routing entries. A register-write port fills that table and a companion table of match entries.

Two lookup modes are selected by a static input. In matching mode the identifier is compared in parallel against every valid match entry, and each entry can mask off the bits it does not care about. Exactly one hit selects the routing entry with the same index. In indexing mode the identifier is itself the routing entry index. A lookup that cannot be routed produces a single-cycle global fault pulse that names the reason: the stream is unknown, two or more entries matched while conflict checking is on, the routing entry holds a fault type, or the entry names a context bank that is not implemented.

The result is registered and appears one clock after the request.

Top module: `smap_router`

## Requirements
- R1: A match word is written with `wr_kind`=0, with the compare ID in bits 15:0 and the mask in bits 31:16. A valid entry hits when every stream ID bit whose mask bit is 0 equals the entry's ID bit. Mask bits of 1 exclude that bit from the compare.
- R2: A match entry's valid flag is written with `wr_kind`=2 from `wr_data[0]`. An entry whose flag is 0 never hits. All flags are 0 after reset.
- R3: In matching mode (`mode_index`=0), a single hit routes the stream using the routing entry at the same index as the hitting match entry.
- R4: When no valid entry hits in matching mode, `flt_unknown` pulses and `rsp_route` reads fault (2'b10).
- R5: With `conflict_chk_en`=1, two or more hits pulse `flt_conflict` and route to fault. With `conflict_chk_en`=0, the lowest-numbered hitting entry is used.
- R6: In indexing mode (`mode_index`=1), the stream ID value is the routing entry index. An ID at or above the number of entries pulses `flt_unknown` and routes to fault.
- R7: A routing word is written with `wr_kind`=1, with the type in bits 17:16 and the context index in bits 7:0. The type values are:
  - 00: translate. `rsp_route`=2'b00 and `rsp_cb` = the index.
  - 01: bypass. `rsp_route`=2'b01 and `rsp_cb`=0.
  - 10 and 11: fault. `flt_badctx` pulses and `rsp_route`=2'b10.
- R8: A translate entry whose index is at or above `NUM_CB` pulses `flt_unimpl` and routes to fault with `rsp_cb`=0.
- R9: A request sampled on one rising edge produces `rsp_valid` and its result on the next edge. At most one fault pulse is high at a time. In a cycle without a response, `rsp_valid`, `rsp_route`, `rsp_cb` and all fault outputs are 0.
- R10: A lookup issued in the same cycle as a table write sees the table as it was before that write. After reset, `rsp_valid` and the fault outputs are low and every routing entry is translate to context 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_index | input | 1 | 1 = indexing mode, 0 = matching mode (static) |
| conflict_chk_en | input | 1 | Enables multiple-hit conflict faults |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | 0 match word, 1 routing word, 2 valid flag, 3 ignored |
| wr_idx | input | $clog2(NUM_ENTRIES) | Entry written |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request |
| req_sid | input | 16 | Stream identifier to look up |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_route | output | 2 | 00 translate, 01 bypass, 10 fault |
| rsp_cb | output | 8 | Context bank index when translating |
| flt_unknown | output | 1 | Unidentified stream fault pulse |
| flt_conflict | output | 1 | Stream match conflict fault pulse |
| flt_badctx | output | 1 | Invalid context (fault-type entry) pulse |
| flt_unimpl | output | 1 | Unimplemented context bank fault pulse |

## Verification
A table write and a lookup can land on the same clock edge. The bench provokes this by rewriting the routing entry that the lookup targets, in the very cycle of the request. It then expects the old routing in that response and the new routing in the next one. Random traffic issues writes and lookups together in many cycles. Each response is judged against a model that applies the write only after computing the expected result.

// File: rtl/smap_pkg.sv
package smap_pkg;

    localparam int SID_W  = 16;
    localparam int CB_W   = 8;
    localparam int WORD_W = 32;

    // table write targets
    localparam logic [1:0] WK_MATCH = 2'd0;
    localparam logic [1:0] WK_ROUTE = 2'd1;
    localparam logic [1:0] WK_VALID = 2'd2;

    typedef enum logic [1:0] {
        RT_XLATE  = 2'b00,
        RT_BYPASS = 2'b01,
        RT_FAULT  = 2'b10
    } route_e;

    typedef enum logic [1:0] {
        EK_XLATE  = 2'b00,
        EK_BYPASS = 2'b01,
        EK_FAULT  = 2'b10,
        EK_RSVD   = 2'b11
    } ent_kind_e;

    typedef struct packed {
        logic [SID_W-1:0] mask;
        logic [SID_W-1:0] id;
    } match_ent_t;

    typedef struct packed {
        ent_kind_e       kind;
        logic [CB_W-1:0] cb;
    } route_ent_t;

    typedef struct packed {
        route_e          route;
        logic [CB_W-1:0] cb;
        logic            unknown;
        logic            conflict;
        logic            badctx;
        logic            unimpl;
    } lookup_t;

    function automatic logic id_hit(match_ent_t e, logic [SID_W-1:0] sid);
        return ((sid ^ e.id) & ~e.mask) == '0;
    endfunction

    function automatic match_ent_t unpack_match(logic [WORD_W-1:0] w);
        match_ent_t e;
        e.id   = w[15:0];
        e.mask = w[31:16];
        return e;
    endfunction

    function automatic route_ent_t unpack_route(logic [WORD_W-1:0] w);
        route_ent_t e;
        e.kind = ent_kind_e'(w[17:16]);
        e.cb   = w[7:0];
        return e;
    endfunction

endpackage

// File: rtl/smap_entry_store.sv
module smap_entry_store
    import smap_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [1:0]                          wr_kind,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [WORD_W-1:0]                   wr_data,
    output match_ent_t [NUM_ENTRIES-1:0]        m_tab,
    output logic       [NUM_ENTRIES-1:0]        m_vld,
    output route_ent_t [NUM_ENTRIES-1:0]        r_tab
);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_tab <= '0;
            m_vld <= '0;
            r_tab <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                WK_MATCH: m_tab[wr_idx] <= unpack_match(wr_data);
                WK_ROUTE: r_tab[wr_idx] <= unpack_route(wr_data);
                WK_VALID: m_vld[wr_idx] <= wr_data[0];
                default:  ;
            endcase
        end
    end

    AST_VALID_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == WK_VALID) |=> (m_vld[$past(wr_idx)] == $past(wr_data[0]))); // R2

endmodule

// File: rtl/smap_match_array.sv
module smap_match_array
    import smap_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  match_ent_t [NUM_ENTRIES-1:0] m_tab,
    input  logic       [NUM_ENTRIES-1:0] m_vld,
    input  logic       [SID_W-1:0]       sid,
    output logic       [NUM_ENTRIES-1:0] hit
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit[g] = m_vld[g] && id_hit(m_tab[g], sid);
    end

endmodule

// File: rtl/smap_hit_resolve.sv
module smap_hit_resolve #(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hit,
    output logic                   any_hit,
    output logic                   multi_hit,
    output logic [IDX_W-1:0]       first_idx
);

    assign any_hit   = |hit;
    assign multi_hit = |(hit & (hit - NUM_ENTRIES'(1)));

    // lowest index wins
    always_comb begin
        first_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) first_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/smap_route_decode.sv
module smap_route_decode
    import smap_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_CB      = 6,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                         mode_index,
    input  logic                         conflict_chk_en,
    input  logic [SID_W-1:0]             sid,
    input  logic                         any_hit,
    input  logic                         multi_hit,
    input  logic [IDX_W-1:0]             first_idx,
    input  route_ent_t [NUM_ENTRIES-1:0] r_tab,
    output lookup_t                      res
);

    logic             found;
    logic [IDX_W-1:0] sel;
    route_ent_t       ent;

    always_comb begin
        if (mode_index) begin
            found = sid < SID_W'(NUM_ENTRIES);
            sel   = sid[IDX_W-1:0];
        end else begin
            found = any_hit;
            sel   = first_idx;
        end
        ent = r_tab[sel];

        res       = '0;
        res.route = RT_FAULT;
        if (!found) begin
            res.unknown = 1'b1;
        end else if (!mode_index && multi_hit && conflict_chk_en) begin
            res.conflict = 1'b1;
        end else begin
            case (ent.kind)
                EK_XLATE: begin
                    if (ent.cb < CB_W'(NUM_CB)) begin
                        res.route = RT_XLATE;
                        res.cb    = ent.cb;
                    end else begin
                        res.unimpl = 1'b1;
                    end
                end
                EK_BYPASS: res.route  = RT_BYPASS;
                default:   res.badctx = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/smap_router.sv
module smap_router
    import smap_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_CB      = 6
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           mode_index,
    input  logic                           conflict_chk_en,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_kind,
    input  logic [$clog2(NUM_ENTRIES)-1:0] wr_idx,
    input  logic [31:0]                    wr_data,
    input  logic                           req_valid,
    input  logic [15:0]                    req_sid,
    output logic                           rsp_valid,
    output logic [1:0]                     rsp_route,
    output logic [7:0]                     rsp_cb,
    output logic                           flt_unknown,
    output logic                           flt_conflict,
    output logic                           flt_badctx,
    output logic                           flt_unimpl
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    match_ent_t [NUM_ENTRIES-1:0] m_tab;
    logic       [NUM_ENTRIES-1:0] m_vld;
    route_ent_t [NUM_ENTRIES-1:0] r_tab;
    logic       [NUM_ENTRIES-1:0] hit;
    logic                         any_hit;
    logic                         multi_hit;
    logic       [IDX_W-1:0]       first_idx;
    lookup_t                      dec;
    lookup_t                      rsp_q;
    logic                         rsp_valid_q;

    smap_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .m_tab   (m_tab),
        .m_vld   (m_vld),
        .r_tab   (r_tab)
    );

    smap_match_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .m_tab (m_tab),
        .m_vld (m_vld),
        .sid   (req_sid),
        .hit   (hit)
    );

    smap_hit_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_resolve (
        .hit       (hit),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .first_idx (first_idx)
    );

    smap_route_decode #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CB(NUM_CB)) u_decode (
        .mode_index      (mode_index),
        .conflict_chk_en (conflict_chk_en),
        .sid             (req_sid),
        .any_hit         (any_hit),
        .multi_hit       (multi_hit),
        .first_idx       (first_idx),
        .r_tab           (r_tab),
        .res             (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_q       <= req_valid ? dec : '0;
        end
    end

    assign rsp_valid    = rsp_valid_q;
    assign rsp_route    = rsp_q.route;
    assign rsp_cb       = rsp_q.cb;
    assign flt_unknown  = rsp_q.unknown;
    assign flt_conflict = rsp_q.conflict;
    assign flt_badctx   = rsp_q.badctx;
    assign flt_unimpl   = rsp_q.unimpl;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_valid || flt_unknown || flt_conflict || flt_badctx || flt_unimpl)); // R9

    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flt_unknown, flt_conflict, flt_badctx, flt_unimpl})); // R9

    AST_FAULT_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (flt_unknown || flt_conflict || flt_badctx || flt_unimpl) |-> (rsp_route == RT_FAULT)); // R4

    AST_CB_RANGE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == RT_XLATE) |-> (rsp_cb < CB_W'(NUM_CB))); // R8

    AST_CONFLICT_MATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_index) |=> !flt_conflict); // R5

endmodule

// File: tb/smap_router_test.sv
`timescale 1ns/1ps
module smap_router_test;

    localparam int N   = 8;
    localparam int NCB = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_index = 1'b0;
    logic        conflict_chk_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [2:0]  wr_idx = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        req_valid = 1'b0;
    logic [15:0] req_sid = 16'd0;
    logic        rsp_valid;
    logic [1:0]  rsp_route;
    logic [7:0]  rsp_cb;
    logic        flt_unknown, flt_conflict, flt_badctx, flt_unimpl;

    int checks = 0;
    int errors = 0;

    // model of the tables
    logic [15:0] m_id   [N];
    logic [15:0] m_mask [N];
    logic        m_v    [N];
    logic [1:0]  r_kind [N];
    logic [7:0]  r_cb   [N];

    always #2.5 clk = ~clk;

    smap_router #(.NUM_ENTRIES(N), .NUM_CB(NCB)) uut (
        .clk(clk), .rst(rst), .mode_index(mode_index), .conflict_chk_en(conflict_chk_en),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_sid(req_sid), .rsp_valid(rsp_valid),
        .rsp_route(rsp_route), .rsp_cb(rsp_cb), .flt_unknown(flt_unknown),
        .flt_conflict(flt_conflict), .flt_badctx(flt_badctx), .flt_unimpl(flt_unimpl)
    );

    function automatic logic [31:0] mword(logic [15:0] id, logic [15:0] mask);
        return {mask, id};
    endfunction

    function automatic logic [31:0] rword(logic [1:0] kind, logic [7:0] cb);
        return {14'd0, kind, 8'd0, cb};
    endfunction

    // {valid, route[1:0], cb[7:0], unknown, conflict, badctx, unimpl}
    function automatic logic [14:0] expect_rsp(logic [15:0] sid);
        int hits = 0;
        int sel  = -1;
        if (mode_index) begin
            if (sid < 16'(N)) sel = int'(sid);
            else return {1'b1, 2'b10, 8'd0, 4'b1000};
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && (((sid ^ m_id[i]) & ~m_mask[i]) == 16'd0)) begin
                    hits++;
                    if (sel < 0) sel = i;
                end
            end
            if (hits == 0) return {1'b1, 2'b10, 8'd0, 4'b1000};
            if (hits > 1 && conflict_chk_en) return {1'b1, 2'b10, 8'd0, 4'b0100};
        end
        case (r_kind[sel])
            2'b00: begin
                if (r_cb[sel] < 8'(NCB)) return {1'b1, 2'b00, r_cb[sel], 4'b0000};
                return {1'b1, 2'b10, 8'd0, 4'b0001};
            end
            2'b01:   return {1'b1, 2'b01, 8'd0, 4'b0000};
            default: return {1'b1, 2'b10, 8'd0, 4'b0010};
        endcase
    endfunction

    function automatic void model_write(logic [1:0] k, logic [2:0] i, logic [31:0] d);
        case (k)
            2'd0: begin m_id[i] = d[15:0]; m_mask[i] = d[31:16]; end
            2'd1: begin r_kind[i] = d[17:16]; r_cb[i] = d[7:0]; end
            2'd2: m_v[i] = d[0];
            default: ;
        endcase
    endfunction

    // drive one cycle of stimulus at a falling edge, check at the next one
    task automatic op(input logic dw, input logic [1:0] k, input logic [2:0] wi,
                      input logic [31:0] wd, input logic dr, input logic [15:0] sid,
                      input string tag);
        logic [14:0] exp_v;
        logic [14:0] act_v;
        exp_v     = dr ? expect_rsp(sid) : 15'd0;
        wr_en     = dw;
        wr_kind   = k;
        wr_idx    = wi;
        wr_data   = wd;
        req_valid = dr;
        req_sid   = sid;
        @(negedge clk);
        act_v = {rsp_valid, rsp_route, rsp_cb, flt_unknown, flt_conflict, flt_badctx, flt_unimpl};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: sid=%h actual=%h expected=%h", tag, sid, act_v, exp_v);
        end
        if (dw) model_write(k, wi, wd);
        wr_en     = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] k, input logic [2:0] wi, input logic [31:0] wd);
        op(1'b1, k, wi, wd, 1'b0, 16'd0, "R9 idle during write");
    endtask

    task automatic look(input logic [15:0] sid, input string tag);
        op(1'b0, 2'd0, 3'd0, 32'd0, 1'b1, sid, tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h5EED);
        for (int i = 0; i < N; i++) begin
            m_id[i] = 16'd0; m_mask[i] = 16'd0; m_v[i] = 1'b0;
            r_kind[i] = 2'd0; r_cb[i] = 8'd0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if ({rsp_valid, flt_unknown, flt_conflict, flt_badctx, flt_unimpl} !== 5'd0) begin
            errors++;
            $display("FAIL R10 reset: actual=%b expected=00000",
                     {rsp_valid, flt_unknown, flt_conflict, flt_badctx, flt_unimpl});
        end
        rst = 1'b0;

        // matching mode, empty table
        look(16'h1234, "R2 R4 nothing valid after reset");

        // R1 R3: masked single hit
        wr(2'd0, 3'd0, mword(16'h1234, 16'h00FF));
        wr(2'd1, 3'd0, rword(2'b00, 8'd3));
        wr(2'd2, 3'd0, 32'd1);
        look(16'h12AB, "R1 R3 masked hit");
        look(16'h13AB, "R1 unmasked bit differs");
        op(1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 16'd0, "R9 no request");

        // R5: two hits
        wr(2'd0, 3'd1, mword(16'h1200, 16'h00FF));
        wr(2'd1, 3'd1, rword(2'b01, 8'd0));
        wr(2'd2, 3'd1, 32'd1);
        look(16'h1255, "R5 conflict detected");
        conflict_chk_en = 1'b0;
        look(16'h1255, "R5 lowest index without check");
        conflict_chk_en = 1'b1;

        // R2: drop entry 0
        wr(2'd2, 3'd0, 32'd0);
        look(16'h1255, "R2 invalid entry ignored");

        // R7 R8: fault types and out-of-range context
        wr(2'd0, 3'd2, mword(16'h7000, 16'h0000));
        wr(2'd1, 3'd2, rword(2'b10, 8'd1));
        wr(2'd2, 3'd2, 32'd1);
        look(16'h7000, "R7 fault type");
        wr(2'd1, 3'd2, rword(2'b11, 8'd1));
        look(16'h7000, "R7 reserved type");
        wr(2'd0, 3'd3, mword(16'h7100, 16'h0000));
        wr(2'd1, 3'd3, rword(2'b00, 8'd7));
        wr(2'd2, 3'd3, 32'd1);
        look(16'h7100, "R8 context above limit");
        wr(2'd1, 3'd3, rword(2'b00, 8'd6));
        look(16'h7100, "R8 context at limit");
        wr(2'd1, 3'd3, rword(2'b00, 8'd5));
        look(16'h7100, "R7 R8 last implemented context");

        // R6: indexing mode
        mode_index = 1'b1;
        look(16'd2, "R6 R7 index to fault entry");
        look(16'd1, "R6 index to bypass");
        look(16'd8, "R6 index out of range");
        look(16'h1255, "R6 R5 no conflict in index mode");

        // R10: write and lookup in the same cycle
        wr(2'd1, 3'd5, rword(2'b00, 8'd1));
        op(1'b1, 2'd1, 3'd5, rword(2'b01, 8'd0), 1'b1, 16'd5, "R10 old contents");
        look(16'd5, "R10 new contents next cycle");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic        dw, dr;
            logic [1:0]  k;
            logic [2:0]  wi;
            logic [31:0] wd;
            logic [15:0] sid;
            if (n % 150 == 0) mode_index = 1'($urandom);
            if (n % 40 == 0) conflict_chk_en = 1'($urandom);
            dw = ($urandom_range(0, 2) == 0);
            k  = 2'($urandom_range(0, 2));
            wi = 3'($urandom);
            case (k)
                2'd0:    wd = mword({12'h4A0, 4'($urandom)}, {12'h000, 4'($urandom)});
                2'd1:    wd = rword(2'($urandom), 8'($urandom_range(0, 7)));
                default: wd = 32'($urandom_range(0, 1));
            endcase
            dr  = ($urandom_range(0, 3) != 0);
            sid = mode_index ? 16'($urandom_range(0, 11)) : {12'h4A0, 4'($urandom)};
            op(dw, k, wi, wd, dr, sid, "R1/R3/R5/R6/R7/R8/R10 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule